// File: doc/BRIEF.md
# Two-Processor Command Mailbox

This block passes commands and replies between a host processor and a coprocessor that run on the same clock. The host has two 16-bit command words, a low word and a high word. It writes them through a narrow bus whose single offset bit selects the word. Writing the high word marks the command as complete and raises an interrupt toward the coprocessor.

The coprocessor reads both command words through its own small register bus. It posts a two-word reply into a pair of reply latches and then acknowledges the interrupt by writing a clear bit. The host reads the reply words back through the same offset bit.

Each host command write zeroes the reply word of the opposite half. A stale reply from an earlier exchange therefore never survives into a new one. Reads on either bus are combinational views of the latches, so a read taken in the same cycle as a write returns the value held before the edge.

Top module: `mbox_latch_top`

## Requirements
- R1: After reset, all four latches read as zero on both buses and the interrupt output is low.
- R2: A host write with h_addr=1 stores h_wdata in the command high latch, which is readable at coprocessor address 1 from the next cycle, and sets irq_o in the next cycle.
- R3: A host write with h_addr=1 sets the reply low latch to zero in the next cycle, unless R10 applies.
- R4: A host write with h_addr=0 stores h_wdata in the command low latch, which is readable at coprocessor address 0. The same write sets the reply high latch to zero in the next cycle, unless R10 applies.
- R5: h_rdata shows the reply high latch when h_addr=1 and the reply low latch when h_addr=0, with no clock delay.
- R6: c_rdata decodes c_addr as follows: 0 gives the command low latch, 1 the command high latch, 2 the reply low latch, 3 the reply high latch, 4 gives {15'b0, irq_o}, and 5 to 7 give zero. The read has no clock delay.
- R7: A coprocessor write to address 2 or 3 loads the reply low or reply high latch. Writes to addresses 0, 1 and 5 to 7 change no latch.
- R8: irq_o stays high until the coprocessor writes address 4 with bit 0 set, and it falls in the next cycle. A write to address 4 with bit 0 clear has no effect.
- R9: If a clear of the interrupt and a host high-word write occur in the same cycle, irq_o is high in the next cycle.
- R10: If a coprocessor reply write and a host invalidation of the same reply latch occur in the same cycle, the latch takes the coprocessor data.
- R11: When a read and a write to the same latch occur in the same cycle, the read returns the value held before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both processors |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 1 | Host word offset: 1 selects the high word, 0 the low word |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data from the reply latches |
| c_we | input | 1 | Coprocessor write strobe |
| c_addr | input | 3 | Coprocessor register address |
| c_wdata | input | 16 | Coprocessor write data |
| c_rdata | output | 16 | Coprocessor read data |
| irq_o | output | 1 | Command-ready interrupt toward the coprocessor |

## Verification
The properties assume that both buses carry known values whenever reset is released. They also assume that the two sides sample on the same edge, since no handshake or synchronizer stands between them. The random stimulus drives every input on the falling edge from a fixed seed. It covers the whole 3-bit coprocessor address range, including the unmapped addresses, and lets host and coprocessor writes collide freely. Directed steps force the priority cases where a clear meets a set and where a reply write meets an invalidation.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W  = 16;
    localparam int CADDR_W = 3;

    localparam logic [CADDR_W-1:0] CA_CMD_LO = 3'd0;
    localparam logic [CADDR_W-1:0] CA_CMD_HI = 3'd1;
    localparam logic [CADDR_W-1:0] CA_RPL_LO = 3'd2;
    localparam logic [CADDR_W-1:0] CA_RPL_HI = 3'd3;
    localparam logic [CADDR_W-1:0] CA_CTRL   = 3'd4;

    localparam int CTRL_CLR_BIT = 0;

    typedef struct packed {
        logic [DATA_W-1:0] cmd_lo;
        logic [DATA_W-1:0] cmd_hi;
        logic [DATA_W-1:0] rpl_lo;
        logic [DATA_W-1:0] rpl_hi;
    } mbox_regs_t;

endpackage

// File: rtl/mbox_host_port.sv
module mbox_host_port
    import mbox_pkg::*;
(
    input  logic              h_we,
    input  logic              h_addr,
    input  logic [DATA_W-1:0] rpl_lo,
    input  logic [DATA_W-1:0] rpl_hi,
    output logic              wr_cmd_lo,
    output logic              wr_cmd_hi,
    output logic [DATA_W-1:0] h_rdata
);

    always_comb begin
        wr_cmd_lo = h_we && !h_addr;
        wr_cmd_hi = h_we &&  h_addr;
        h_rdata   = h_addr ? rpl_hi : rpl_lo;
    end

endmodule

// File: rtl/mbox_cop_port.sv
module mbox_cop_port
    import mbox_pkg::*;
(
    input  logic               c_we,
    input  logic [CADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0]  c_wdata,
    input  mbox_regs_t         regs,
    input  logic               irq,
    output logic               wr_rpl_lo,
    output logic               wr_rpl_hi,
    output logic               irq_clr,
    output logic [DATA_W-1:0]  c_rdata
);

    always_comb begin
        wr_rpl_lo = c_we && (c_addr == CA_RPL_LO);
        wr_rpl_hi = c_we && (c_addr == CA_RPL_HI);
        irq_clr   = c_we && (c_addr == CA_CTRL) && c_wdata[CTRL_CLR_BIT];
        unique case (c_addr)
            CA_CMD_LO: c_rdata = regs.cmd_lo;
            CA_CMD_HI: c_rdata = regs.cmd_hi;
            CA_RPL_LO: c_rdata = regs.rpl_lo;
            CA_RPL_HI: c_rdata = regs.rpl_hi;
            CA_CTRL:   c_rdata = {{(DATA_W-1){1'b0}}, irq};
            default:   c_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    logic irq_d, irq_q;

    // set outranks clear so a fresh command is never lost
    always_comb begin
        irq_d = irq_q;
        if (clr_i) irq_d = 1'b0;
        if (set_i) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_i) |=> irq_q);
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_q);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> irq_q);

endmodule

// File: rtl/mbox_latch_top.sv
module mbox_latch_top
    import mbox_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_we,
    input  logic               h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    input  logic               c_we,
    input  logic [CADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0]  c_wdata,
    output logic [DATA_W-1:0]  c_rdata,
    output logic               irq_o
);

    mbox_regs_t regs_d, regs_q;
    logic wr_cmd_lo, wr_cmd_hi;
    logic wr_rpl_lo, wr_rpl_hi, irq_clr;

    mbox_host_port u_host (
        .h_we      (h_we),
        .h_addr    (h_addr),
        .rpl_lo    (regs_q.rpl_lo),
        .rpl_hi    (regs_q.rpl_hi),
        .wr_cmd_lo (wr_cmd_lo),
        .wr_cmd_hi (wr_cmd_hi),
        .h_rdata   (h_rdata)
    );

    mbox_cop_port u_cop (
        .c_we      (c_we),
        .c_addr    (c_addr),
        .c_wdata   (c_wdata),
        .regs      (regs_q),
        .irq       (irq_o),
        .wr_rpl_lo (wr_rpl_lo),
        .wr_rpl_hi (wr_rpl_hi),
        .irq_clr   (irq_clr),
        .c_rdata   (c_rdata)
    );

    mbox_irq_ctl u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wr_cmd_hi),
        .clr_i (irq_clr),
        .irq_o (irq_o)
    );

    // host invalidation first, coprocessor reply written last wins
    always_comb begin
        regs_d = regs_q;
        if (wr_cmd_lo) begin
            regs_d.cmd_lo = h_wdata;
            regs_d.rpl_hi = '0;
        end
        if (wr_cmd_hi) begin
            regs_d.cmd_hi = h_wdata;
            regs_d.rpl_lo = '0;
        end
        if (wr_rpl_lo) regs_d.rpl_lo = c_wdata;
        if (wr_rpl_hi) regs_d.rpl_hi = c_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    p_cmd_hi_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr) |=> (regs_q.cmd_hi == $past(h_wdata)));
    p_irq_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr) |=> irq_o);
    p_rpl_lo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr && !(c_we && c_addr == CA_RPL_LO)) |=> (regs_q.rpl_lo == '0));
    p_rpl_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && !h_addr && !(c_we && c_addr == CA_RPL_HI)) |=> (regs_q.rpl_hi == '0));
    p_cmd_lo_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && !h_addr) |=> (regs_q.cmd_lo == $past(h_wdata)));
    p_cmd_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_we) |=> $stable(regs_q.cmd_lo) && $stable(regs_q.cmd_hi));
    p_reply_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && c_addr == CA_RPL_LO) |=> (regs_q.rpl_lo == $past(c_wdata)));

endmodule

// File: tb/sim_mbox_latch_top.sv
module sim_mbox_latch_top;

    localparam int CLK_P  = 10;
    localparam int NRAND  = 3000;
    localparam int WDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 1'b0, h_addr = 1'b0;
    logic [15:0] h_wdata = '0, h_rdata;
    logic        c_we = 1'b0;
    logic [2:0]  c_addr = '0;
    logic [15:0] c_wdata = '0, c_rdata;
    logic        irq_o;

    int nvec = 0, nbad = 0, ncyc = 0;
    logic [15:0] m_clo = '0, m_chi = '0, m_rlo = '0, m_rhi = '0;
    logic        m_irq = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mbox_latch_top u0 (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .irq_o(irq_o)
    );

    function automatic logic [15:0] exp_c(input logic [2:0] a);
        case (a)
            3'd0: return m_clo;
            3'd1: return m_chi;
            3'd2: return m_rlo;
            3'd3: return m_rhi;
            3'd4: return {15'b0, m_irq};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive on the falling edge, check pre-edge outputs, then advance the model
    task automatic step(input logic hwe, input logic ha, input logic [15:0] hwd,
                        input logic cwe, input logic [2:0] ca, input logic [15:0] cwd,
                        input string tag);
        @(negedge clk);
        h_we = hwe; h_addr = ha; h_wdata = hwd;
        c_we = cwe; c_addr = ca; c_wdata = cwd;
        #1;
        chk({tag, " R5 host read"}, h_rdata, ha ? m_rhi : m_rlo);
        chk({tag, " R6 cop read"}, c_rdata, exp_c(ca));
        chk({tag, " R8 irq"}, {15'b0, irq_o}, {15'b0, m_irq});
        @(posedge clk);
        if (hwe && !ha) begin m_clo = hwd; m_rhi = '0; end
        if (hwe &&  ha) begin m_chi = hwd; m_rlo = '0; end
        if (cwe && ca == 3'd2) m_rlo = cwd;
        if (cwe && ca == 3'd3) m_rhi = cwd;
        if (cwe && ca == 3'd4 && cwd[0]) m_irq = 1'b0;
        if (hwe && ha) m_irq = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            ncyc++;
            if (ncyc > WDOG) begin
                nbad++;
                $display("FAIL watchdog: actual %0d expected <= %0d cycles", ncyc, WDOG);
                $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every address reads zero after reset
        for (int a = 0; a < 8; a++) step(0, a[0], 16'h0, 0, a[2:0], 16'h0, "R1");

        // R7: reply low written, then R2 and R3 via a high command write
        step(0, 0, 16'h0, 1, 3'd2, 16'h1111, "R7");
        step(0, 0, 16'h0, 0, 3'd2, 16'h0, "R7");
        step(1, 1, 16'hA5A5, 0, 3'd1, 16'h0, "R2");
        step(0, 0, 16'h0, 0, 3'd1, 16'h0, "R2 R3");

        // R4: low command zeroes reply high
        step(0, 0, 16'h0, 1, 3'd3, 16'h2222, "R4");
        step(1, 0, 16'h3333, 0, 3'd3, 16'h0, "R4");
        step(0, 1, 16'h0, 0, 3'd0, 16'h0, "R4");

        // R7: command latches are read-only from the coprocessor
        step(0, 0, 16'h0, 1, 3'd0, 16'hFFFF, "R7");
        step(0, 0, 16'h0, 1, 3'd6, 16'hFFFF, "R7");
        step(0, 0, 16'h0, 0, 3'd0, 16'h0, "R7");

        // R8: clear bit 0 low has no effect, set clears
        step(0, 0, 16'h0, 1, 3'd4, 16'hFFFE, "R8");
        step(0, 0, 16'h0, 1, 3'd4, 16'h0001, "R8");
        step(0, 0, 16'h0, 0, 3'd4, 16'h0, "R8");

        // R9: clear and high command in one cycle
        step(1, 1, 16'h4444, 1, 3'd4, 16'h0001, "R9");
        step(0, 0, 16'h0, 0, 3'd4, 16'h0, "R9");

        // R10: reply write beats invalidation
        step(1, 1, 16'h5555, 1, 3'd2, 16'h7777, "R10");
        step(1, 0, 16'h6666, 1, 3'd3, 16'h8888, "R10");
        step(0, 0, 16'h0, 0, 3'd2, 16'h0, "R10");
        step(0, 1, 16'h0, 0, 3'd3, 16'h0, "R10");

        // R11: read and write the same latch in one cycle
        step(0, 0, 16'h0, 1, 3'd2, 16'h9999, "R11");
        step(1, 1, 16'hBBBB, 0, 3'd1, 16'h0, "R11");
        step(0, 0, 16'h0, 0, 3'd2, 16'h0, "R11");

        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0] < 4'd5, r[4], $urandom,
                 r[8:5] < 4'd6, r[11:9],
                 r[12] ? 16'h0001 : 16'($urandom), "rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule